// File: doc/BRIEF.md
# One-Wire ROM Search Accelerator

This block is the bit engine of a one-wire bus master, extended with a search mode that speeds up the binary walk over device identities. In plain mode, each byte the host hands over goes out least significant bit first as eight time slots. Every slot is either a write-0 slot or a write-1 slot, and a write-1 slot doubles as a read slot. The line level sampled in each slot is gathered into a received byte.

In search mode, one host byte carries four direction choices. For each of the four positions, the engine runs three slots with no host involvement: a read of the identity bit, a read of its complement, and a write of the chosen direction. It then returns one byte in which the chosen bits and the conflict flags alternate. Sixteen such exchanges walk all 64 identity bits, least significant nibble first. The host enters the mode after it has reset the bus and sent the search command, and it leaves the mode by clearing it and resetting the bus. Every result byte comes back through the same receive holding register as a plain read.

All slot timing is counted in clock cycles, and the cycle counts are parameters. The bus pin is an open-drain pull-low request together with the sampled line level.

Top module: `ow_search_accel`

## Requirements
- R1: After a synchronous reset, `rd_ready`, `busy` and `bus_pull_low` are low.
- R2: In plain mode, a written byte produces exactly 8 slots, sent bit 0 first. A 0 bit holds the line low for `LOW_W0` cycles and a 1 bit for `LOW_W1` cycles. Bit k of the received byte is the line level sampled `SAMPLE_AT` cycles into slot k.
- R3: In search mode, a written byte produces exactly 12 slots, grouped as 4 triples of read, read and direction write. Both reads hold the line low for `LOW_W1` cycles.
- R4: When the identity bit read and its complement read differ, the direction written is the bit that was read, and the conflict flag is 0.
- R5: When both reads return 0, the direction written is host byte bit 2p+1 for position p (p = 0..3), and the conflict flag is 1.
- R6: When both reads return 1 (no device answering), the direction written is 1 and the conflict flag is 1.
- R7: In the search result byte, bit 2p+1 holds the direction written at position p and bit 2p holds its conflict flag. Result byte i supplies identity bits 4i..4i+3.
- R8: When a byte ends, its result is loaded into `rd_byte` and `rd_ready` rises with `busy` low. `rd_ready` stays high until `rd_stb` is pulsed, and it is low in the cycle after that pulse.
- R9: A `wr_stb` pulse while `busy` is high is ignored. It neither changes the byte in progress nor starts another one.
- R10: The mode is captured when the byte is accepted. Changing `search_mode` while the byte runs does not change its slot count or its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| search_mode | input | 1 | Selects search mode for the next accepted byte |
| wr_stb | input | 1 | Host byte strobe, accepted only while idle |
| wr_byte | input | DW | Host byte: plain data, or the search directions in the odd bits |
| busy | output | 1 | High while a byte is in progress |
| rd_stb | input | 1 | Host acknowledges the received byte |
| rd_byte | output | DW | Received byte or search result |
| rd_ready | output | 1 | Receive holding register full |
| bus_in | input | 1 | Sampled level of the wired-AND line |
| bus_pull_low | output | 1 | Request to pull the line low (open drain) |

## Verification
The bench attaches several behavioural devices with distinct 64-bit identities to a wired-AND line. It compares every search result byte and every direction-slot width against a bench model of the walk. The corner cases it targets are the first bit where two identities diverge, an empty bus and a lone device. A design that swapped the flag and bit lanes, or that ignored the host direction on a conflict, would recover the wrong identity or set the flag at the wrong bit. A design that wrote 0 on an empty bus would return zeros in place of all-ones. The bench also strikes `wr_stb` and clears `search_mode` in the middle of a byte, which catches a design that re-samples the mode or reloads the data while busy.

// File: rtl/ow_search_pkg.sv
package ow_search_pkg;

    // Slot flavour: a write-1 slot is also the read slot.
    typedef enum logic {
        SLOT_W0 = 1'b0,
        SLOT_W1 = 1'b1
    } slot_kind_t;

    // Position inside one search triple.
    typedef enum logic [1:0] {
        PH_BIT = 2'd0,
        PH_CMP = 2'd1,
        PH_DIR = 2'd2
    } tri_phase_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_t;

    // Outcome of one search position.
    typedef struct packed {
        logic dir;
        logic flag;
    } pick_t;

    // Choose the direction from the two reads and the host hint.
    function automatic pick_t resolve(input logic bit_v, input logic cmp_v,
                                      input logic host_dir);
        pick_t p;
        if (bit_v != cmp_v) begin
            p.dir  = bit_v;
            p.flag = 1'b0;
        end else if (!bit_v) begin
            p.dir  = host_dir;
            p.flag = 1'b1;
        end else begin
            p.dir  = 1'b1;
            p.flag = 1'b1;
        end
        return p;
    endfunction

endpackage

// File: rtl/ow_slot_timer.sv
module ow_slot_timer
    import ow_search_pkg::*;
#(
    parameter int SLOT_CYC  = 40,
    parameter int LOW_W0    = 30,
    parameter int LOW_W1    = 4,
    parameter int SAMPLE_AT = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  slot_kind_t kind,
    input  logic       line_in,
    output logic       pull_low,
    output logic       done,
    output logic       smp,
    output logic       active
);
    localparam int CW = $clog2(SLOT_CYC + 1);
    localparam logic [CW-1:0] C_END = CW'(SLOT_CYC - 1);
    localparam logic [CW-1:0] C_L0  = CW'(LOW_W0);
    localparam logic [CW-1:0] C_L1  = CW'(LOW_W1);
    localparam logic [CW-1:0] C_SMP = CW'(SAMPLE_AT);

    logic [CW-1:0] cnt;
    logic [CW-1:0] low_len;
    slot_kind_t    kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            kind_q <= SLOT_W1;
            smp    <= 1'b1;
        end else if (!active) begin
            if (go) begin
                active <= 1'b1;
                cnt    <= '0;
                kind_q <= kind;
            end
        end else begin
            if (cnt == C_SMP) begin
                smp <= line_in;
            end
            if (cnt == C_END) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign low_len  = (kind_q == SLOT_W0) ? C_L0 : C_L1;
    assign pull_low = active && (cnt < low_len);
    assign done     = active && (cnt == C_END);

    // R2: the line is only pulled low in answer to a slot request
    a_r2_pull_after_go: assert property (@(posedge clk) disable iff (rst)
        $rose(pull_low) |-> $past(go));

    // R3: a new slot is never requested while one is running
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
        go |-> !active);

endmodule

// File: rtl/ow_sequencer.sv
module ow_sequencer
    import ow_search_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          search_mode,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_byte,
    input  logic          slot_done,
    input  logic          slot_smp,
    input  logic          slot_active,
    output logic          go,
    output slot_kind_t    kind,
    output logic          push,
    output logic [DW-1:0] push_data,
    output logic          busy
);
    localparam int POS  = DW / 2;
    localparam int IDXW = $clog2(DW);
    localparam logic [IDXW-1:0] LAST_PLAIN  = IDXW'(DW - 1);
    localparam logic [IDXW-1:0] LAST_SEARCH = IDXW'(POS - 1);

    seq_state_t    state;
    tri_phase_t    phase;
    logic          mode_q;
    logic [DW-1:0] tx_q;
    logic [DW-1:0] acc;
    logic [IDXW-1:0] idx;
    logic          bit_q;
    logic          cmp_q;
    pick_t         pick;
    logic [IDXW-1:0] dir_lane;
    logic [IDXW-1:0] flag_lane;

    assign dir_lane  = {idx[IDXW-2:0], 1'b1};
    assign flag_lane = {idx[IDXW-2:0], 1'b0};
    assign pick      = resolve(bit_q, cmp_q, tx_q[dir_lane]);

    always_comb begin
        if (!mode_q) begin
            kind = tx_q[idx] ? SLOT_W1 : SLOT_W0;
        end else if (phase == PH_DIR) begin
            kind = pick.dir ? SLOT_W1 : SLOT_W0;
        end else begin
            kind = SLOT_W1;
        end
    end

    assign go        = (state == SQ_ISSUE);
    assign busy      = (state != SQ_IDLE) || push;
    assign push_data = acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            phase  <= PH_BIT;
            mode_q <= 1'b0;
            tx_q   <= '0;
            acc    <= '0;
            idx    <= '0;
            bit_q  <= 1'b1;
            cmp_q  <= 1'b1;
            push   <= 1'b0;
        end else begin
            push <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (wr_stb && !push) begin
                        tx_q   <= wr_byte;
                        mode_q <= search_mode;
                        idx    <= '0;
                        phase  <= PH_BIT;
                        acc    <= '0;
                        state  <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: begin
                    state <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (slot_done) begin
                        state <= SQ_ISSUE;
                        if (!mode_q) begin
                            acc[idx] <= slot_smp;
                            if (idx == LAST_PLAIN) begin
                                push  <= 1'b1;
                                state <= SQ_IDLE;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            case (phase)
                                PH_BIT: begin
                                    bit_q <= slot_smp;
                                    phase <= PH_CMP;
                                end
                                PH_CMP: begin
                                    cmp_q <= slot_smp;
                                    phase <= PH_DIR;
                                end
                                default: begin
                                    acc[dir_lane]  <= pick.dir;
                                    acc[flag_lane] <= pick.flag;
                                    phase          <= PH_BIT;
                                    if (idx == LAST_SEARCH) begin
                                        push  <= 1'b1;
                                        state <= SQ_IDLE;
                                    end else begin
                                        idx <= idx + 1'b1;
                                    end
                                end
                            endcase
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R9: the byte being worked on stays put while busy
    a_r9_data_held: assert property (@(posedge clk) disable iff (rst)
        (state != SQ_IDLE && $past(state != SQ_IDLE)) |-> $stable(tx_q));

    // R10: the mode captured at acceptance stays put while busy
    a_r10_mode_held: assert property (@(posedge clk) disable iff (rst)
        (state != SQ_IDLE && $past(state != SQ_IDLE)) |-> $stable(mode_q));

    // R3: slot completions arrive only while a slot is awaited
    a_r3_done_in_wait: assert property (@(posedge clk) disable iff (rst)
        slot_done |-> (state == SQ_WAIT && slot_active));

    // R6: no answer on either read forces a write-1 slot
    a_r6_empty_writes_one: assert property (@(posedge clk) disable iff (rst)
        (go && mode_q && phase == PH_DIR && bit_q && cmp_q) |-> (kind == SLOT_W1));

    // R4: a clean bit is echoed back on the direction slot
    a_r4_echo_bit: assert property (@(posedge clk) disable iff (rst)
        (go && mode_q && phase == PH_DIR && (bit_q != cmp_q)) |->
            (kind == (bit_q ? SLOT_W1 : SLOT_W0)));

endmodule

// File: rtl/ow_rx_hold.sv
module ow_rx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          rd_stb,
    output logic [DW-1:0] rd_byte,
    output logic          rd_ready
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_byte  <= '0;
            rd_ready <= 1'b0;
        end else if (push) begin
            rd_byte  <= push_data;
            rd_ready <= 1'b1;
        end else if (rd_stb) begin
            rd_ready <= 1'b0;
        end
    end

    // R8: a finished byte always marks the buffer full
    a_r8_full_on_push: assert property (@(posedge clk) disable iff (rst)
        push |=> rd_ready);

    // R8: an acknowledge without a new byte empties the buffer
    a_r8_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !push) |=> !rd_ready);

endmodule

// File: rtl/ow_search_accel.sv
module ow_search_accel
    import ow_search_pkg::*;
#(
    parameter int DW        = 8,
    parameter int SLOT_CYC  = 40,
    parameter int LOW_W0    = 30,
    parameter int LOW_W1    = 4,
    parameter int SAMPLE_AT = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          search_mode,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_byte,
    output logic          busy,
    input  logic          rd_stb,
    output logic [DW-1:0] rd_byte,
    output logic          rd_ready,
    input  logic          bus_in,
    output logic          bus_pull_low
);
    logic          go;
    slot_kind_t    kind;
    logic          slot_done;
    logic          slot_smp;
    logic          slot_active;
    logic          push;
    logic [DW-1:0] push_data;

    ow_slot_timer #(
        .SLOT_CYC (SLOT_CYC),
        .LOW_W0   (LOW_W0),
        .LOW_W1   (LOW_W1),
        .SAMPLE_AT(SAMPLE_AT)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .kind    (kind),
        .line_in (bus_in),
        .pull_low(bus_pull_low),
        .done    (slot_done),
        .smp     (slot_smp),
        .active  (slot_active)
    );

    ow_sequencer #(
        .DW(DW)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .search_mode(search_mode),
        .wr_stb     (wr_stb),
        .wr_byte    (wr_byte),
        .slot_done  (slot_done),
        .slot_smp   (slot_smp),
        .slot_active(slot_active),
        .go         (go),
        .kind       (kind),
        .push       (push),
        .push_data  (push_data),
        .busy       (busy)
    );

    ow_rx_hold #(
        .DW(DW)
    ) u_rx (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_data(push_data),
        .rd_stb   (rd_stb),
        .rd_byte  (rd_byte),
        .rd_ready (rd_ready)
    );

    // R1: reset leaves the bus released and the buffer empty
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!rd_ready && !bus_pull_low && !busy));

    // R8: a full buffer is only ever reported with the engine idle or done
    a_r8_ready_rise_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_ready) |-> !bus_pull_low);

endmodule

// File: tb/test_ow_search_accel.sv
module test_ow_search_accel;
    localparam int SLOT = 40;
    localparam int L0   = 30;
    localparam int L1   = 4;
    localparam int SMP  = 10;
    localparam int HOLD = 20;
    localparam int WSMP = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       search_mode = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       rd_stb = 1'b0;
    logic       busy;
    logic [7:0] rd_byte;
    logic       rd_ready;
    logic       bus_in;
    logic       bus_pull_low;

    always #4 clk = ~clk;

    ow_search_accel #(
        .DW(8), .SLOT_CYC(SLOT), .LOW_W0(L0), .LOW_W1(L1), .SAMPLE_AT(SMP)
    ) i_ow_search_accel (
        .clk(clk), .rst(rst), .search_mode(search_mode), .wr_stb(wr_stb),
        .wr_byte(wr_byte), .busy(busy), .rd_stb(rd_stb), .rd_byte(rd_byte),
        .rd_ready(rd_ready), .bus_in(bus_in), .bus_pull_low(bus_pull_low)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // ---------------- device models on a wired-AND line ----------------
    logic [63:0] ids [4];
    logic [3:0]  s_alive = 4'h0;
    logic [3:0]  s_low = 4'h0;
    logic        r_low = 1'b0;
    bit          search_on = 0;
    bit          norm_on = 0;
    logic [7:0]  norm_byte = 8'hFF;
    int          norm_bit = 0;
    int          s_phase = 0;
    int          s_pos = 0;
    int          s_cnt = 0;
    bit          in_slot = 0;
    logic        prev_pull = 1'b0;

    assign bus_in = !bus_pull_low && !(|s_low) && !r_low;

    always @(negedge clk) begin
        if (bus_pull_low && !prev_pull) begin
            s_cnt   = 0;
            in_slot = 1;
        end else if (in_slot) begin
            s_cnt++;
        end
        prev_pull = bus_pull_low;
        s_low = 4'h0;
        r_low = 1'b0;
        if (in_slot) begin
            if (norm_on) begin
                if (s_cnt < HOLD) r_low = !norm_byte[norm_bit];
                if (s_cnt == HOLD) begin
                    norm_bit = (norm_bit + 1) % 8;
                    in_slot = 0;
                end
            end else if (search_on) begin
                if (s_phase < 2) begin
                    if (s_cnt < HOLD) begin
                        for (int k = 0; k < 4; k++)
                            s_low[k] = s_alive[k] &&
                                ((s_phase == 0) ? !ids[k][s_pos] : ids[k][s_pos]);
                    end else begin
                        s_phase++;
                        in_slot = 0;
                    end
                end else if (s_cnt == WSMP) begin
                    for (int k = 0; k < 4; k++)
                        if (ids[k][s_pos] != !bus_pull_low) s_alive[k] = 1'b0;
                    s_pos++;
                    s_phase = 0;
                    in_slot = 0;
                end
            end else begin
                in_slot = 0;
            end
        end
    end

    // ---------------- slot monitor ----------------
    int   mon_n = 0;
    int   mon_run = 0;
    int   mon_w [16];
    logic prev_busy = 1'b0;

    always @(negedge clk) begin
        if (busy && !prev_busy) begin
            mon_n   = 0;
            mon_run = 0;
        end
        prev_busy = busy;
        if (bus_pull_low) begin
            mon_run++;
        end else if (mon_run > 0) begin
            if (mon_n < 16) mon_w[mon_n] = mon_run;
            mon_n++;
            mon_run = 0;
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- host tasks ----------------
    task automatic xfer(input logic [7:0] d, input bit srch, input bit disturb,
                        output logic [7:0] r);
        @(negedge clk);
        search_mode = srch;
        wr_byte = d;
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        if (disturb) begin
            repeat (60) @(negedge clk);
            wr_byte = ~d;
            search_mode = !srch;
            wr_stb = 1'b1;
            @(negedge clk);
            wr_stb = 1'b0;
        end
        while (!rd_ready) @(negedge clk);
        chk(!busy, "R8 busy low with result", busy, 0);
        r = rd_byte;
        @(negedge clk);
        search_mode = srch;
        chk(rd_ready && rd_byte == r, "R8 result held until read", rd_byte, r);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk(!rd_ready, "R8 cleared by read", rd_ready, 0);
    endtask

    task automatic arm(input logic [3:0] mask);
        @(posedge clk);
        norm_on   = 0;
        search_on = 1;
        s_alive   = mask;
        s_phase   = 0;
        s_pos     = 0;
    endtask

    // dir_mode: 0 all directions 0, 1 all 1, 2 random
    task automatic run_search(input logic [3:0] mask, input int dir_mode,
                              input int disturb_at, output logic [63:0] got);
        logic [3:0]  m_alive;
        logic [63:0] m_id;
        logic [7:0]  tx, exp, r;
        int          kase [4];
        arm(mask);
        m_alive = mask;
        m_id = '0;
        got = '0;
        for (int i = 0; i < 16; i++) begin
            tx = (dir_mode == 0) ? 8'h00 : (dir_mode == 1) ? 8'hFF : 8'($urandom);
            exp = 8'h00;
            for (int p = 0; p < 4; p++) begin
                logic a, b, dir, flag;
                int pos;
                pos = 4 * i + p;
                a = 1'b1;
                b = 1'b1;
                for (int k = 0; k < 4; k++)
                    if (m_alive[k]) begin
                        a = a & ids[k][pos];
                        b = b & !ids[k][pos];
                    end
                if (a != b) begin dir = a;          flag = 1'b0; kase[p] = 4; end
                else if (!a) begin dir = tx[2*p+1]; flag = 1'b1; kase[p] = 5; end
                else begin dir = 1'b1;              flag = 1'b1; kase[p] = 6; end
                exp[2*p+1] = dir;
                exp[2*p]   = flag;
                m_id[pos]  = dir;
                for (int k = 0; k < 4; k++)
                    if (ids[k][pos] != dir) m_alive[k] = 1'b0;
            end
            xfer(tx, 1'b1, (i == disturb_at), r);
            chk(r == exp, (i == disturb_at) ? "R9 R10 result unaffected" : "R7 result byte", r, exp);
            chk(mon_n == 12, (i == disturb_at) ? "R10 slot count" : "R3 slot count", mon_n, 12);
            for (int p = 0; p < 4; p++) begin
                int ew;
                ew = exp[2*p+1] ? L1 : L0;
                chk(mon_w[3*p] == L1 && mon_w[3*p+1] == L1, "R3 read slot width",
                    mon_w[3*p], L1);
                case (kase[p])
                    4: chk(mon_w[3*p+2] == ew, "R4 direction slot", mon_w[3*p+2], ew);
                    5: chk(mon_w[3*p+2] == ew, "R5 direction slot", mon_w[3*p+2], ew);
                    default: chk(mon_w[3*p+2] == ew, "R6 direction slot", mon_w[3*p+2], ew);
                endcase
                got[4*i+p] = r[2*p+1];
            end
        end
        chk(got == m_id, "R7 assembled identity", got, m_id);
    endtask

    // ---------------- main ----------------
    initial begin
        logic [7:0]  r;
        logic [63:0] got;
        ids[0] = 64'h1122_3344_5566_7718;
        ids[1] = 64'h99AA_BBCC_DDEE_FF38;
        ids[2] = 64'hC0FF_EE00_1234_5607;
        ids[3] = 64'h0F0F_0F0F_F0F0_F0E1;
        void'($urandom(32'h5EED_1234));

        repeat (4) @(negedge clk);
        chk(!rd_ready && !busy && !bus_pull_low, "R1 reset state",
            {rd_ready, busy, bus_pull_low}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!rd_ready && !busy && !bus_pull_low, "R1 idle after reset",
            {rd_ready, busy, bus_pull_low}, 0);

        // plain mode: R2
        norm_on = 1; norm_bit = 0; norm_byte = 8'hFF;
        xfer(8'hA5, 1'b0, 1'b0, r);
        chk(r == 8'hA5, "R2 plain echo", r, 8'hA5);
        chk(mon_n == 8, "R2 slot count", mon_n, 8);
        for (int k = 0; k < 8; k++) begin
            int ew;
            ew = ((8'hA5 >> k) & 1) ? L1 : L0;
            chk(mon_w[k] == ew, "R2 slot width, bit 0 first", mon_w[k], ew);
        end
        norm_byte = 8'h3C;
        xfer(8'hFF, 1'b0, 1'b0, r);
        chk(r == 8'h3C, "R2 plain read", r, 8'h3C);
        norm_byte = 8'h5A;
        xfer(8'h96, 1'b0, 1'b0, r);
        chk(r == (8'h96 & 8'h5A), "R2 plain mixed", r, 8'h96 & 8'h5A);

        // R4: lone device
        run_search(4'b0100, 2, -1, got);
        chk(got == ids[2], "R4 lone device identity", got, ids[2]);

        // R5: two devices first diverge at bit 5
        run_search(4'b0011, 0, -1, got);
        chk(got == ids[0], "R5 zero branch identity", got, ids[0]);
        run_search(4'b0011, 1, -1, got);
        chk(got == ids[1], "R5 one branch identity", got, ids[1]);

        // R6: empty bus
        run_search(4'b0000, 0, -1, got);
        chk(got == 64'hFFFF_FFFF_FFFF_FFFF, "R6 empty bus identity", got, 64'hFFFF_FFFF_FFFF_FFFF);

        // R9 R10: strobe and mode change during byte 3
        run_search(4'b1000, 2, 3, got);
        chk(got == ids[3], "R9 identity after disturb", got, ids[3]);

        // random device sets and directions
        for (int t = 0; t < 3; t++) begin
            logic [3:0] mask;
            mask = 4'($urandom) | 4'b0001;
            run_search(mask, 2, -1, got);
            chk(got == ids[0] || got == ids[1] || got == ids[2] || got == ids[3],
                "R7 random walk hits a device", got, 0);
        end

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule